// File: doc/BRIEF.md
# GPIO Data and Direction Register Bank

This block is a 32-pin general-purpose I/O port controlled through a small register bus with single-cycle access. Software writes an output latch and a per-pin direction mask. The block drives an output-enable and an output value for every pin. Each pin's input level passes through a two-flop synchronizer before software can read it. A read of the data word always returns that synchronized pin level, even for pins configured as outputs. A read that follows a write too closely can therefore still show the old level.

A separate read-only word returns the output latch itself, so software can recover exactly what it last wrote. A per-pin keep mask selects the pins whose latch and direction bits survive an active-low soft reset. An asynchronous hard reset clears every register, including the keep mask.

Top module: `gpio_bank`

## Requirements
- R1: While and after the hard reset `rst_ni` is low, the latch, direction and keep registers are all zero, `pin_oe_o` and `pin_out_o` are zero, and `rdata_o` is zero.
- R2: A write to byte address 0x00 loads `wdata_i` into the output latch. A read of byte address 0x08 returns the latch contents.
- R3: Byte address 0x04 is the read/write direction word. Bit value 1 makes a pin an output and 0 makes it an input. `pin_oe_o` equals the direction word, and `pin_out_o` equals latch AND direction, so an input pin drives 0.
- R4: A read of byte address 0x00 returns the two-flop synchronized `pin_i`, whatever the direction. A level applied before rising edge k shows up only in a read whose strobe is sampled at edge k+2 or later.
- R5: A write to the latch readback address 0x08 changes no register and no output.
- R6: Byte address 0x0C is the read/write keep mask, one bit per pin.
- R7: A rising edge with `soft_rst_ni` low clears the latch and direction bits whose keep bit is 0. It leaves the bits whose keep bit is 1 and the keep mask itself unchanged, and it overrides a write presented in the same cycle.
- R8: Every byte address other than 0x00, 0x04, 0x08 and 0x0C reads as zero, and a write to such an address changes nothing.
- R9: A read strobe sampled at a rising edge puts its data on `rdata_o` just after that edge. In any cycle that follows an edge without a read strobe, `rdata_o` is zero.
- R10: A read and a write to the same register sampled at the same edge return the value held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low hard reset |
| soft_rst_ni | input | 1 | Synchronous active-low soft reset, gated by the keep mask |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| addr_i | input | 6 | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| pin_i | input | 32 | Pin input levels |
| pin_oe_o | output | 32 | Pin output enables |
| pin_out_o | output | 32 | Pin output values |

## Verification
The assertions assume that `soft_rst_ni` is a synchronous level sampled at the clock and that the bus strobes never go unknown once hard reset is released. The bench changes strobes, address, data, pins and the soft reset only on the falling edge, so every value is stable when the rising edge samples it. The assertions on latch loading are qualified with the soft reset being high, because R7 lets the soft reset override a write. The bench exercises that collision on purpose.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int unsigned ADDR_W = 6;

  localparam logic [ADDR_W-1:0] OFF_DATA  = 6'h00;
  localparam logic [ADDR_W-1:0] OFF_DIR   = 6'h04;
  localparam logic [ADDR_W-1:0] OFF_LATCH = 6'h08;
  localparam logic [ADDR_W-1:0] OFF_KEEP  = 6'h0C;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_DATA,
    SEL_DIR,
    SEL_LATCH,
    SEL_KEEP
  } reg_sel_e;

  function automatic reg_sel_e decode_addr(input logic [ADDR_W-1:0] a);
    case (a)
      OFF_DATA:  return SEL_DATA;
      OFF_DIR:   return SEL_DIR;
      OFF_LATCH: return SEL_LATCH;
      OFF_KEEP:  return SEL_KEEP;
      default:   return SEL_NONE;
    endcase
  endfunction
endpackage

// File: rtl/gpio_bank_sync.sv
module gpio_bank_sync #(
  parameter int unsigned WIDTH  = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg_q[0] <= '0;
    else         stg_q[0] <= async_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[s] <= '0;
      else         stg_q[s] <= stg_q[s-1];
    end
  end

  assign sync_o = stg_q[STAGES-1];
endmodule

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs
  import gpio_bank_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             soft_rst_ni,
  input  logic             wr_en_i,
  input  reg_sel_e         sel_i,
  input  logic [WIDTH-1:0] wdata_i,
  output logic [WIDTH-1:0] latch_o,
  output logic [WIDTH-1:0] dir_o,
  output logic [WIDTH-1:0] keep_o
);
  logic [WIDTH-1:0] latch_q, dir_q, keep_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      latch_q <= '0;
      dir_q   <= '0;
      keep_q  <= '0;
    end else if (!soft_rst_ni) begin
      // tolerant pins hold, others clear; keep mask untouched
      latch_q <= latch_q & keep_q;
      dir_q   <= dir_q & keep_q;
    end else if (wr_en_i) begin
      case (sel_i)
        SEL_DATA: latch_q <= wdata_i;
        SEL_DIR:  dir_q   <= wdata_i;
        SEL_KEEP: keep_q  <= wdata_i;
        default: ;
      endcase
    end
  end

  assign latch_o = latch_q;
  assign dir_o   = dir_q;
  assign keep_o  = keep_q;

  // R2
  latch_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && soft_rst_ni && sel_i == SEL_DATA) |=> latch_o == $past(wdata_i));

  // R7
  soft_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !soft_rst_ni |=> ((latch_o | dir_o) & ~keep_o) == '0);

  // R7
  soft_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !soft_rst_ni |=> (keep_o == $past(keep_o)) &&
                     ((latch_o & keep_o) == $past(latch_o & keep_o)) &&
                     ((dir_o & keep_o) == $past(dir_o & keep_o)));

  // R5 R8
  ignored_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && soft_rst_ni && (sel_i == SEL_LATCH || sel_i == SEL_NONE))
      |=> $stable(latch_o) && $stable(dir_o) && $stable(keep_o));
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_bank_pkg::*;
#(
  parameter int unsigned WIDTH       = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              soft_rst_ni,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [5:0]        addr_i,
  input  logic [WIDTH-1:0]  wdata_i,
  output logic [WIDTH-1:0]  rdata_o,
  input  logic [WIDTH-1:0]  pin_i,
  output logic [WIDTH-1:0]  pin_oe_o,
  output logic [WIDTH-1:0]  pin_out_o
);
  reg_sel_e         sel;
  logic [WIDTH-1:0] latch, dir, keep, pin_sync;
  logic [WIDTH-1:0] rd_mux, rdata_q;

  assign sel = decode_addr(addr_i);

  gpio_bank_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) sync_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i (pin_i),
    .sync_o  (pin_sync)
  );

  gpio_bank_regs #(.WIDTH(WIDTH)) regs_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .soft_rst_ni (soft_rst_ni),
    .wr_en_i     (wr_en_i),
    .sel_i       (sel),
    .wdata_i     (wdata_i),
    .latch_o     (latch),
    .dir_o       (dir),
    .keep_o      (keep)
  );

  always_comb begin
    case (sel)
      SEL_DATA:  rd_mux = pin_sync;
      SEL_DIR:   rd_mux = dir;
      SEL_LATCH: rd_mux = latch;
      SEL_KEEP:  rd_mux = keep;
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rdata_q <= '0;
    else if (rd_en_i) rdata_q <= rd_mux;
    else              rdata_q <= '0;
  end

  assign rdata_o   = rdata_q;
  assign pin_oe_o  = dir;
  assign pin_out_o = latch & dir;

  // R2
  latch_readback_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && sel == SEL_LATCH) |=> rdata_o == $past(latch));

  // R9
  idle_rdata_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> rdata_o == '0);

  // R8
  unmapped_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && sel == SEL_NONE) |=> rdata_o == '0);

  // R3
  tristate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pin_out_o & ~pin_oe_o) == '0);
endmodule

// File: tb/gpio_bank_tb_top.sv
module gpio_bank_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        soft_rst_ni = 1'b1;
  logic        wr_en_i = 1'b0;
  logic        rd_en_i = 1'b0;
  logic [5:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] pin_i = '0;
  logic [31:0] rdata_o, pin_oe_o, pin_out_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [31:0] m_latch = '0, m_dir = '0, m_keep = '0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  gpio_bank dut_i (
    .clk_i, .rst_ni, .soft_rst_ni, .wr_en_i, .rd_en_i, .addr_i,
    .wdata_i, .rdata_o, .pin_i, .pin_oe_o, .pin_out_o
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    @(posedge clk_i); #1;
    wr_en_i = 1'b0;
    case (a)
      6'h00: m_latch = d;
      6'h04: m_dir = d;
      6'h0C: m_keep = d;
      default: ;
    endcase
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] v);
    @(negedge clk_i);
    rd_en_i = 1'b1; addr_i = a;
    @(posedge clk_i); #1;
    v = rdata_o;
    rd_en_i = 1'b0;
  endtask

  task automatic check_state(input string req);
    logic [31:0] v;
    rd(6'h08, v); check({req, " latch"}, v, m_latch);
    rd(6'h04, v); check({req, " dir"}, v, m_dir);
    rd(6'h0C, v); check({req, " keep"}, v, m_keep);
    check({req, " oe"}, pin_oe_o, m_dir);
    check({req, " out"}, pin_out_o, m_latch & m_dir);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, v1, v2, v3;
    // R1 reset state
    repeat (3) @(posedge clk_i);
    #1;
    check("R1 oe in reset", pin_oe_o, '0);
    check("R1 out in reset", pin_out_o, '0);
    check("R1 rdata in reset", rdata_o, '0);
    @(negedge clk_i); rst_ni = 1'b1;
    check_state("R1");

    // R2 R3 walking sweep of latch against direction
    for (int i = 0; i < 32; i++) begin
      logic [31:0] pat;
      pat = (32'h1 << i) ^ 32'hA5C3_0F96;
      wr(6'h00, pat);
      wr(6'h04, ~(32'h1 << i) & 32'h3C3C_F0F0 | (32'h1 << i));
      rd(6'h08, v); check("R2 latch readback", v, m_latch);
      rd(6'h04, v); check("R3 dir readback", v, m_dir);
      check("R3 pin_oe", pin_oe_o, m_dir);
      check("R3 pin_out", pin_out_o, m_latch & m_dir);
    end

    // R4 synchronizer latency, independent of direction
    wr(6'h04, 32'hFFFF_0000);
    @(negedge clk_i);
    pin_i = 32'h1234_5678; rd_en_i = 1'b1; addr_i = 6'h00;
    @(posedge clk_i); #1; v1 = rdata_o;
    @(posedge clk_i); #1; v2 = rdata_o;
    @(posedge clk_i); #1; v3 = rdata_o;
    rd_en_i = 1'b0;
    check("R4 first edge old", v1, 32'h0);
    check("R4 second edge old", v2, 32'h0);
    check("R4 third edge new", v3, 32'h1234_5678);
    // R9 idle cycle reads zero
    @(posedge clk_i); #1;
    check("R9 idle rdata", rdata_o, '0);
    for (int i = 0; i < 32; i++) begin
      @(negedge clk_i); pin_i = ~(32'h1 << i);
      repeat (2) @(posedge clk_i);
      rd(6'h00, v); check("R4 pin sweep", v, ~(32'h1 << i));
    end

    // R10 read during write returns old value
    @(negedge clk_i);
    wr_en_i = 1'b1; rd_en_i = 1'b1; addr_i = 6'h04; wdata_i = 32'h0F0F_0F0F;
    @(posedge clk_i); #1;
    check("R10 read old dir", rdata_o, m_dir);
    wr_en_i = 1'b0; rd_en_i = 1'b0; m_dir = 32'h0F0F_0F0F;
    check_state("R10");

    // R6 keep mask, R7 soft reset with colliding write
    wr(6'h00, 32'hFFFF_FFFF);
    wr(6'h04, 32'hFFFF_FFFF);
    for (int k = 0; k < 4; k++) begin
      logic [31:0] kp;
      kp = (k == 0) ? 32'h0 : (k == 1) ? 32'hFFFF_FFFF : (k == 2) ? 32'h00FF_F00F : 32'h8000_0001;
      wr(6'h00, 32'hDEAD_BEEF ^ {k[7:0], 24'h0});
      wr(6'h04, 32'hF0F0_FF00 | kp);
      wr(6'h0C, kp);
      rd(6'h0C, v); check("R6 keep readback", v, kp);
      @(negedge clk_i);
      soft_rst_ni = 1'b0; wr_en_i = 1'b1; addr_i = 6'h00; wdata_i = 32'h5555_AAAA;
      @(posedge clk_i); #1;
      soft_rst_ni = 1'b1; wr_en_i = 1'b0;
      m_latch = m_latch & m_keep;
      m_dir = m_dir & m_keep;
      check_state("R7");
    end

    // R5 write to readback address ignored
    wr(6'h00, 32'h1357_9BDF); wr(6'h04, 32'hFFFF_00FF); wr(6'h0C, 32'h0000_FFFF);
    wr(6'h08, 32'hFFFF_FFFF);
    check_state("R5");

    // R8 unmapped sweep
    for (int a = 0; a < 64; a++) begin
      if (a != 0 && a != 4 && a != 8 && a != 12) begin
        rd(a[5:0], v); check("R8 unmapped read", v, '0);
        wr(a[5:0], 32'hFFFF_FFFF);
      end
    end
    check_state("R8");

    // R1 hard reset clears keep as well
    @(negedge clk_i); rst_ni = 1'b0;
    #1;
    check("R1 hard reset oe", pin_oe_o, '0);
    @(negedge clk_i); rst_ni = 1'b1;
    m_latch = '0; m_dir = '0; m_keep = '0;
    check_state("R1 after hard reset");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule